// File: doc/BRIEF.md
# Double-Buffered Audio Transfer Controller

This controller moves a continuous stream of 32-bit audio words between a word-addressed memory and an audio serializer, independently in the receive and the transmit direction. Software programs a receive pointer, a transmit pointer, a word count shared by both directions and a direction-enable mask. It then writes a start strobe. Each enabled direction copies its live pointer into an internal address register and counts through the buffer one word at a time.

Each copy raises a per-direction pointer event. After that event, software may write the pointer register again with the next buffer. When the current buffer is used up, the controller copies that queued pointer and carries on with no gap. Streaming stops only when software writes the stop strobe. After the stop, the words already in flight complete, the block goes idle and it raises a single stopped event. Every event has its own interrupt enable, and one level-sensitive interrupt line combines them.

Register map (word offsets on `reg_addr_i`):
- 0x0: start strobe.
- 0x1: stop strobe.
- 0x2: receive pointer event.
- 0x3: transmit pointer event.
- 0x4: stopped event.
- 0x5: interrupt enable set.
- 0x6: interrupt enable clear.
- 0x7: receive pointer.
- 0x8: transmit pointer.
- 0x9: word count.
- 0xA: direction enable.

A word count of 0 is treated as 1.

Top module: `audio_xfer_ctrl`

## Requirements
- R1: Direction enable register 0xA: bit 0 enables receive, bit 1 enables transmit. The mask is sampled when a start is accepted. A disabled direction makes no memory request, keeps `rx_ready_o` or `tx_valid_o` low, and raises no pointer event.
- R2: Writing a value with bit 0 set to offset 0x0 while idle starts a transfer. Each enabled direction copies its live pointer (receive 0x7, transmit 0x8) and sets its pointer event (receive 0x2, transmit 0x3) on the same clock edge. Its first memory word address equals that pointer.
- R3: After the number of words in register 0x9, the direction copies the live pointer again and sets its pointer event again. Within one buffer, word addresses rise by one per word.
- R4: Received words are written to memory in arrival order at successive addresses. A memory request held without a grant keeps its address and data.
- R5: Transmit words are read in address order and offered to the serializer in the same order. A word offered without `tx_ready_i` stays stable.
- R6: Writing a value with bit 0 set to offset 0x1 while running ends the transfer. No new word is accepted. A word already captured or requested still completes. The block then goes idle and sets the stopped event (0x4) exactly once. A stop written while idle has no effect.
- R7: An event register reads 1 while the event is pending. Writing 0 to it clears it. Writing a nonzero value to it has no effect.
- R8: Writing 1s to 0x5 sets interrupt enable bits and writing 1s to 0x6 clears them. Reading either offset returns the mask. The bits are: 0 receive pointer event, 1 transmit pointer event, 2 stopped event.
- R9: `irq_o` is high exactly when some pending event has its enable bit set.
- R10: After reset, all events, enables, pointers and the count read 0, `irq_o` is low and no handshake or memory request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Combined interrupt |
| mem_wr_req_o | output | 1 | Receive-side memory write request |
| mem_wr_addr_o | output | AW | Write word address |
| mem_wr_data_o | output | DW | Write data |
| mem_wr_gnt_i | input | 1 | Write grant |
| mem_rd_req_o | output | 1 | Transmit-side memory read request |
| mem_rd_addr_o | output | AW | Read word address |
| mem_rd_gnt_i | input | 1 | Read grant |
| mem_rd_valid_i | input | 1 | Read data valid |
| mem_rd_data_i | input | DW | Read data |
| rx_valid_i | input | 1 | Serializer receive word valid |
| rx_ready_o | output | 1 | Controller ready for a receive word |
| rx_data_i | input | DW | Receive word |
| tx_valid_o | output | 1 | Transmit word valid |
| tx_ready_i | input | 1 | Serializer ready for a transmit word |
| tx_data_o | output | DW | Transmit word |

## Verification
The receive-only pattern queues new pointers after each pointer event, so wrong reload timing shows up as words landing at the wrong address. It also stops with a word captured, which separates a dropped in-flight word from a completed one. The transmit-only pattern stalls the serializer at buffer edges, which tells a reload at grant time apart from a reload at delivery time and exposes reordering. A random run with both directions, a random count and random grant and ready stalls shows whether the two address sequences interfere. Directed cases cover a stop while idle, nonzero writes to event registers and mask set and clear against `irq_o`.

// File: rtl/audio_xfer_pkg.sv
package audio_xfer_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} xfer_state_e;

  localparam int unsigned NUM_DIR = 2;
  localparam int unsigned DIR_RX  = 0;
  localparam int unsigned DIR_TX  = 1;
  localparam int unsigned NUM_EV  = 3;
  localparam int unsigned EV_STOP = 2;
  localparam int unsigned REG_W   = 32;

  localparam logic [3:0] OFS_START  = 4'h0;
  localparam logic [3:0] OFS_STOP   = 4'h1;
  localparam logic [3:0] OFS_EV_RX  = 4'h2;
  localparam logic [3:0] OFS_EV_TX  = 4'h3;
  localparam logic [3:0] OFS_EV_STP = 4'h4;
  localparam logic [3:0] OFS_IE_SET = 4'h5;
  localparam logic [3:0] OFS_IE_CLR = 4'h6;
  localparam logic [3:0] OFS_RX_PTR = 4'h7;
  localparam logic [3:0] OFS_TX_PTR = 4'h8;
  localparam logic [3:0] OFS_COUNT  = 4'h9;
  localparam logic [3:0] OFS_DIR_EN = 4'hA;
endpackage

// File: rtl/xfer_addr_seq.sv
module xfer_addr_seq #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          adv_i,
  input  logic [AW-1:0] ptr_i,
  input  logic [CW-1:0] cnt_i,
  output logic [AW-1:0] addr_o,
  output logic          upd_o
);
  logic [AW-1:0] addr_q;
  logic [CW-1:0] left_q;
  logic [CW-1:0] cnt_eff;
  logic          last;

  assign cnt_eff = (cnt_i == '0) ? CW'(1) : cnt_i;
  assign last    = (left_q == CW'(1));
  // shadow copy at start and on buffer exhaustion
  assign upd_o   = start_i | (adv_i & last);
  assign addr_o  = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      left_q <= '0;
    end else if (upd_o) begin
      addr_q <= ptr_i;
      left_q <= cnt_eff;
    end else if (adv_i) begin
      addr_q <= addr_q + AW'(1);
      left_q <= left_q - CW'(1);
    end
  end
endmodule

// File: rtl/xfer_ctrl_regs.sv
module xfer_ctrl_regs
  import audio_xfer_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [3:0]         addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  input  logic [NUM_EV-1:0]  ev_set_i,
  output logic               start_o,
  output logic               stop_o,
  output logic [AW-1:0]      rx_ptr_o,
  output logic [AW-1:0]      tx_ptr_o,
  output logic [CW-1:0]      cnt_o,
  output logic [NUM_DIR-1:0] dir_en_o,
  output logic               irq_o
);
  logic [NUM_EV-1:0]  ev_q, ie_q, ev_clr;
  logic [AW-1:0]      rx_ptr_q, tx_ptr_q;
  logic [CW-1:0]      cnt_q;
  logic [NUM_DIR-1:0] dir_en_q;

  assign start_o = wr_i && addr_i == OFS_START && wdata_i[0];
  assign stop_o  = wr_i && addr_i == OFS_STOP && wdata_i[0];

  always_comb begin
    for (int e = 0; e < NUM_EV; e++)
      ev_clr[e] = wr_i && (addr_i == OFS_EV_RX + 4'(e)) && (wdata_i == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_q     <= '0;
      ie_q     <= '0;
      rx_ptr_q <= '0;
      tx_ptr_q <= '0;
      cnt_q    <= '0;
      dir_en_q <= '0;
    end else begin
      ev_q <= (ev_q & ~ev_clr) | ev_set_i;
      if (wr_i) begin
        case (addr_i)
          OFS_IE_SET: ie_q     <= ie_q | wdata_i[NUM_EV-1:0];
          OFS_IE_CLR: ie_q     <= ie_q & ~wdata_i[NUM_EV-1:0];
          OFS_RX_PTR: rx_ptr_q <= wdata_i[AW-1:0];
          OFS_TX_PTR: tx_ptr_q <= wdata_i[AW-1:0];
          OFS_COUNT:  cnt_q    <= wdata_i[CW-1:0];
          OFS_DIR_EN: dir_en_q <= wdata_i[NUM_DIR-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr_i)
      OFS_EV_RX:  rdata_o = REG_W'(ev_q[0]);
      OFS_EV_TX:  rdata_o = REG_W'(ev_q[1]);
      OFS_EV_STP: rdata_o = REG_W'(ev_q[EV_STOP]);
      OFS_IE_SET,
      OFS_IE_CLR: rdata_o = REG_W'(ie_q);
      OFS_RX_PTR: rdata_o = REG_W'(rx_ptr_q);
      OFS_TX_PTR: rdata_o = REG_W'(tx_ptr_q);
      OFS_COUNT:  rdata_o = REG_W'(cnt_q);
      OFS_DIR_EN: rdata_o = REG_W'(dir_en_q);
      default:    rdata_o = '0;
    endcase
  end

  assign rx_ptr_o = rx_ptr_q;
  assign tx_ptr_o = tx_ptr_q;
  assign cnt_o    = cnt_q;
  assign dir_en_o = dir_en_q;
  assign irq_o    = |(ev_q & ie_q);
endmodule

// File: rtl/xfer_rx_path.sv
module xfer_rx_path #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          ser_valid_i,
  output logic          ser_ready_o,
  input  logic [DW-1:0] ser_data_i,
  input  logic [AW-1:0] addr_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o,
  input  logic          mem_gnt_i,
  output logic          adv_o,
  output logic          busy_o
);
  logic          hold_q;
  logic [DW-1:0] data_q;

  assign ser_ready_o = en_i & ~hold_q;
  assign mem_req_o   = hold_q;
  assign mem_addr_o  = addr_i;
  assign mem_data_o  = data_q;
  assign adv_o       = hold_q & mem_gnt_i;
  assign busy_o      = hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      data_q <= '0;
    end else if (ser_valid_i && ser_ready_o) begin
      hold_q <= 1'b1;
      data_q <= ser_data_i;
    end else if (adv_o) begin
      hold_q <= 1'b0;
    end
  end
endmodule

// File: rtl/xfer_tx_path.sv
module xfer_tx_path #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_gnt_i,
  input  logic          mem_valid_i,
  input  logic [DW-1:0] mem_data_i,
  output logic          ser_valid_o,
  input  logic          ser_ready_i,
  output logic [DW-1:0] ser_data_o,
  output logic          adv_o,
  output logic          busy_o
);
  logic          req_q, pend_q, full_q;
  logic [DW-1:0] buf_q;

  assign mem_req_o   = req_q;
  assign mem_addr_o  = addr_i;
  assign adv_o       = req_q & mem_gnt_i;
  assign ser_valid_o = full_q;
  assign ser_data_o  = buf_q;
  assign busy_o      = req_q | pend_q | full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
      full_q <= 1'b0;
      buf_q  <= '0;
    end else begin
      // request stays up once raised, even if the run ends
      if (adv_o) req_q <= 1'b0;
      else if (en_i && !req_q && !pend_q && !full_q) req_q <= 1'b1;
      if (adv_o) pend_q <= 1'b1;
      else if (mem_valid_i) pend_q <= 1'b0;
      if (pend_q && mem_valid_i) begin
        full_q <= 1'b1;
        buf_q  <= mem_data_i;
      end else if (full_q && ser_ready_i) begin
        full_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/audio_xfer_ctrl.sv
module audio_xfer_ctrl
  import audio_xfer_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          irq_o,
  output logic          mem_wr_req_o,
  output logic [AW-1:0] mem_wr_addr_o,
  output logic [DW-1:0] mem_wr_data_o,
  input  logic          mem_wr_gnt_i,
  output logic          mem_rd_req_o,
  output logic [AW-1:0] mem_rd_addr_o,
  input  logic          mem_rd_gnt_i,
  input  logic          mem_rd_valid_i,
  input  logic [DW-1:0] mem_rd_data_i,
  input  logic          rx_valid_i,
  output logic          rx_ready_o,
  input  logic [DW-1:0] rx_data_i,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic [DW-1:0] tx_data_o
);
  xfer_state_e        state_q, state_d;
  logic               reg_start, reg_stop, start_go, stop_done, irq;
  logic [NUM_DIR-1:0] dir_en, run_en_q, seq_start, seq_adv, seq_upd, dir_busy;
  logic [AW-1:0]      rx_ptr, tx_ptr;
  logic [CW-1:0]      word_cnt;
  logic [AW-1:0]      live_ptr [NUM_DIR];
  logic [AW-1:0]      seq_addr [NUM_DIR];
  logic [NUM_EV-1:0]  ev_set;

  xfer_ctrl_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .ev_set_i(ev_set),
    .start_o(reg_start), .stop_o(reg_stop),
    .rx_ptr_o(rx_ptr), .tx_ptr_o(tx_ptr), .cnt_o(word_cnt),
    .dir_en_o(dir_en), .irq_o(irq)
  );
  assign irq_o = irq;

  assign start_go  = reg_start && state_q == ST_IDLE;
  assign stop_done = state_q == ST_DRAIN && dir_busy == '0;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (reg_start) state_d = ST_RUN;
      ST_RUN:   if (reg_stop) state_d = ST_DRAIN;
      ST_DRAIN: if (stop_done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      run_en_q <= '0;
    end else begin
      state_q <= state_d;
      if (start_go) run_en_q <= dir_en;
    end
  end

  assign live_ptr[DIR_RX] = rx_ptr;
  assign live_ptr[DIR_TX] = tx_ptr;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    assign seq_start[d] = start_go & dir_en[d];
    xfer_addr_seq #(.AW(AW), .CW(CW)) u_seq (
      .clk_i, .rst_ni,
      .start_i(seq_start[d]), .adv_i(seq_adv[d]),
      .ptr_i(live_ptr[d]), .cnt_i(word_cnt),
      .addr_o(seq_addr[d]), .upd_o(seq_upd[d])
    );
  end

  assign ev_set = {stop_done, seq_upd};

  xfer_rx_path #(.AW(AW), .DW(DW)) u_rx (
    .clk_i, .rst_ni,
    .en_i(state_q == ST_RUN && run_en_q[DIR_RX]),
    .ser_valid_i(rx_valid_i), .ser_ready_o(rx_ready_o), .ser_data_i(rx_data_i),
    .addr_i(seq_addr[DIR_RX]),
    .mem_req_o(mem_wr_req_o), .mem_addr_o(mem_wr_addr_o),
    .mem_data_o(mem_wr_data_o), .mem_gnt_i(mem_wr_gnt_i),
    .adv_o(seq_adv[DIR_RX]), .busy_o(dir_busy[DIR_RX])
  );

  xfer_tx_path #(.AW(AW), .DW(DW)) u_tx (
    .clk_i, .rst_ni,
    .en_i(state_q == ST_RUN && run_en_q[DIR_TX]),
    .addr_i(seq_addr[DIR_TX]),
    .mem_req_o(mem_rd_req_o), .mem_addr_o(mem_rd_addr_o),
    .mem_gnt_i(mem_rd_gnt_i), .mem_valid_i(mem_rd_valid_i),
    .mem_data_i(mem_rd_data_i),
    .ser_valid_o(tx_valid_o), .ser_ready_i(tx_ready_i), .ser_data_o(tx_data_o),
    .adv_o(seq_adv[DIR_TX]), .busy_o(dir_busy[DIR_TX])
  );
endmodule

// File: rtl/xfer_ctrl_chk.sv
module xfer_ctrl_chk
  import audio_xfer_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input xfer_state_e   state_i,
  input logic          mem_wr_req_o,
  input logic [AW-1:0] mem_wr_addr_o,
  input logic [DW-1:0] mem_wr_data_o,
  input logic          mem_wr_gnt_i,
  input logic          mem_rd_req_o,
  input logic [AW-1:0] mem_rd_addr_o,
  input logic          mem_rd_gnt_i,
  input logic          rx_ready_o,
  input logic          tx_valid_o,
  input logic          tx_ready_i,
  input logic [DW-1:0] tx_data_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_IDLE |-> !mem_wr_req_o && !mem_rd_req_o && !rx_ready_o && !tx_valid_o);

  p_wr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_req_o && !mem_wr_gnt_i |=> mem_wr_req_o && $stable(mem_wr_addr_o) && $stable(mem_wr_data_o));

  p_rd_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_req_o && !mem_rd_gnt_i |=> mem_rd_req_o && $stable(mem_rd_addr_o));

  p_tx_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  p_no_accept_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i != ST_RUN |-> !rx_ready_o);
endmodule

bind audio_xfer_ctrl xfer_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i, .rst_ni, .state_i(state_q),
  .mem_wr_req_o, .mem_wr_addr_o, .mem_wr_data_o, .mem_wr_gnt_i,
  .mem_rd_req_o, .mem_rd_addr_o, .mem_rd_gnt_i,
  .rx_ready_o, .tx_valid_o, .tx_ready_i, .tx_data_o
);

// File: tb/audio_xfer_ctrl_test.sv
`timescale 1ns/1ps
module audio_xfer_ctrl_test;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic reg_wr_i = 1'b0;
  logic [3:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic irq_o;
  logic mem_wr_req_o, mem_wr_gnt_i = 1'b0;
  logic [AW-1:0] mem_wr_addr_o, mem_rd_addr_o;
  logic [DW-1:0] mem_wr_data_o, mem_rd_data_i = '0, rx_data_i = '0, tx_data_o;
  logic mem_rd_req_o, mem_rd_gnt_i = 1'b0, mem_rd_valid_i = 1'b0;
  logic rx_valid_i = 1'b0, rx_ready_o, tx_valid_o, tx_ready_i = 1'b0;

  always #2 clk_i = ~clk_i;

  audio_xfer_ctrl uut (.*);

  int checks = 0, failures = 0;
  int unsigned rx_limit = 0, rx_sent = 0, tx_limit = 0, tx_n = 0, wr_cnt = 0;
  int unsigned rd_cycles = 0, rdy_cycles = 0;
  logic [31:0] mem [256];
  logic [31:0] tx_got [64];

  function automatic logic [31:0] tx_init(int a);
    return 32'hA500_0000 | 32'(a);
  endfunction
  function automatic logic [31:0] rx_word(int i);
    return 32'hC0DE_0000 + 32'(i);
  endfunction
  function automatic int rx_addr_a(int i);
    return (i < 4) ? 16'h10 + i : (i < 8) ? 16'h40 + i - 4 : 16'h50 + i - 8;
  endfunction
  function automatic int tx_addr_b(int i);
    return (i < 5) ? 16'h80 + i : 16'hC0 + i - 5;
  endfunction

  always @(negedge clk_i) begin
    mem_wr_gnt_i <= ($urandom % 4) != 0;
    mem_rd_gnt_i <= ($urandom % 3) != 0;
    rx_valid_i   <= (rx_sent < rx_limit) && (($urandom % 3) != 0);
    rx_data_i    <= rx_word(int'(rx_sent));
    tx_ready_i   <= (tx_n < tx_limit) && (($urandom % 2) == 0);
  end

  always @(posedge clk_i) begin
    if (rst_ni) begin
      if (rx_valid_i && rx_ready_o) rx_sent <= rx_sent + 1;
      if (mem_wr_req_o && mem_wr_gnt_i) begin
        mem[mem_wr_addr_o[7:0]] <= mem_wr_data_o;
        wr_cnt <= wr_cnt + 1;
      end
      mem_rd_valid_i <= mem_rd_req_o && mem_rd_gnt_i;
      mem_rd_data_i  <= mem[mem_rd_addr_o[7:0]];
      if (tx_valid_o && tx_ready_i) begin
        tx_got[tx_n[5:0]] <= tx_data_o;
        tx_n <= tx_n + 1;
      end
      if (mem_rd_req_o) rd_cycles <= rd_cycles + 1;
      if (rx_ready_o) rdy_cycles <= rdy_cycles + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic wait_stopped();
    logic [31:0] v = 0;
    while (v != 1) rd(4'h4, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++; checks++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int unsigned w0, r0, k, n0, s0;
    bit ok;
    void'($urandom(32'h5EED_0A11));
    for (int a = 0; a < 256; a++) mem[a] = tx_init(a);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R10 reset state
    ok = 1;
    for (int a = 2; a <= 10; a++) begin
      rd(4'(a), v);
      if (v != 0) ok = 0;
    end
    check(ok && !irq_o && !rx_ready_o && !tx_valid_o && !mem_wr_req_o && !mem_rd_req_o,
          "R10", "reset registers and outputs", {27'd0, irq_o, rx_ready_o, tx_valid_o, mem_wr_req_o, mem_rd_req_o}, 0);

    // R8 mask set/clear
    wr(4'h5, 32'h7); wr(4'h6, 32'h2);
    rd(4'h5, v); check(v == 32'h5, "R8", "mask via set offset", v, 32'h5);
    rd(4'h6, v); check(v == 32'h5, "R8", "mask via clear offset", v, 32'h5);
    wr(4'h6, 32'h7);

    // R6 stop while idle has no effect
    wr(4'h1, 32'h1); repeat (4) @(negedge clk_i);
    rd(4'h4, v); check(v == 0, "R6", "stop while idle", v, 0);

    // Scenario A: receive only, two reloads, stop with word in flight
    r0 = rd_cycles;
    wr(4'h9, 32'd4); wr(4'h7, 32'h10); wr(4'hA, 32'h1);
    wr(4'h0, 32'h1);
    rd(4'h2, v); check(v == 1, "R2", "rx pointer event at start", v, 1);
    rd(4'h3, v); check(v == 0, "R1", "tx event stays clear when disabled", v, 0);
    wr(4'h2, 32'h5); rd(4'h2, v); check(v == 1, "R7", "nonzero write keeps event", v, 1);
    wr(4'h2, 32'h0); rd(4'h2, v); check(v == 0, "R7", "zero write clears event", v, 0);
    wr(4'h2, 32'h1); rd(4'h2, v); check(v == 0, "R7", "nonzero write does not set event", v, 0);
    wr(4'h7, 32'h40);
    rx_limit = 4;
    while (wr_cnt < 4) @(negedge clk_i);
    rd(4'h2, v); check(v == 1, "R3", "rx event after count words", v, 1);
    wr(4'h5, 32'h1); @(negedge clk_i);
    check(irq_o == 1'b1, "R9", "irq with rx event enabled", irq_o, 1);
    wr(4'h2, 32'h0); @(negedge clk_i);
    check(irq_o == 1'b0, "R9", "irq after event cleared", irq_o, 0);
    wr(4'h6, 32'h1); wr(4'h7, 32'h50);
    rx_limit = 8;
    while (wr_cnt < 8) @(negedge clk_i);
    wr(4'h2, 32'h0);
    rx_limit = 11;
    while (rx_sent < 11) @(negedge clk_i);
    wr(4'h1, 32'h1);
    wr(4'h5, 32'h4);
    wait_stopped();
    check(irq_o == 1'b1, "R9", "irq on stopped event", irq_o, 1);
    rx_limit = 20;
    repeat (40) @(negedge clk_i);
    check(wr_cnt == 11, "R6", "in-flight word written, none after", wr_cnt, 11);
    check(rx_sent == 11, "R6", "no words accepted after stop", rx_sent, 11);
    ok = 1;
    for (int i = 0; i < 11; i++) if (mem[rx_addr_a(i)] != rx_word(i)) ok = 0;
    check(ok, "R4", "rx words at reloaded addresses in order", mem[8'h52], rx_word(10));
    check(mem[8'h14] == tx_init(8'h14), "R3", "no rx write past buffer end", mem[8'h14], tx_init(8'h14));
    check(rd_cycles == r0, "R1", "no read requests with tx disabled", rd_cycles - r0, 0);
    wr(4'h4, 32'h0); wr(4'h6, 32'h4);
    repeat (20) @(negedge clk_i);
    rd(4'h4, v); check(v == 0, "R6", "stopped event raised only once", v, 0);
    rx_limit = 11;

    // Scenario B: transmit only with reload and serializer stalls
    w0 = wr_cnt; s0 = rdy_cycles; n0 = tx_n;
    wr(4'h9, 32'd5); wr(4'h8, 32'h80); wr(4'hA, 32'h2);
    wr(4'h0, 32'h1);
    rd(4'h3, v); check(v == 1, "R2", "tx pointer event at start", v, 1);
    wr(4'h3, 32'h0); wr(4'h8, 32'hC0);
    tx_limit = n0 + 5;
    while (tx_n < n0 + 5) @(negedge clk_i);
    repeat (6) @(negedge clk_i);
    rd(4'h3, v); check(v == 1, "R3", "tx event after count words", v, 1);
    wr(4'h3, 32'h0); wr(4'h8, 32'hE0);
    tx_limit = n0 + 8;
    while (tx_n < n0 + 8) @(negedge clk_i);
    wr(4'h1, 32'h1);
    tx_limit = n0 + 60;
    wait_stopped();
    repeat (10) @(negedge clk_i);
    k = tx_n - n0;
    check(k >= 8 && k <= 10, "R6", "tx words after stop drain", k, 8);
    ok = 1;
    for (int i = 0; i < int'(k); i++) if (tx_got[6'(n0 + i)] != tx_init(tx_addr_b(i))) ok = 0;
    check(ok, "R5", "tx word order across reload", tx_got[6'(n0 + 5)], tx_init(8'hC0));
    check(wr_cnt == w0 && rdy_cycles == s0, "R1", "rx idle while disabled", wr_cnt - w0, 0);
    wr(4'h4, 32'h0);

    // Scenario C: both directions, random count, random stalls
    for (int rep = 0; rep < 3; rep++) begin
      k = 2 + ($urandom % 4);
      n0 = tx_n; s0 = rx_sent; w0 = wr_cnt;
      wr(4'h9, k); wr(4'h7, 32'h60 + rep * 8); wr(4'h8, 32'hA0 + rep * 8); wr(4'hA, 32'h3);
      wr(4'h0, 32'h1);
      rd(4'h2, v); check(v == 1, "R2", "rx event with both enabled", v, 1);
      rd(4'h3, v); check(v == 1, "R2", "tx event with both enabled", v, 1);
      wr(4'h2, 32'h0); wr(4'h3, 32'h0);
      rx_limit = s0 + k; tx_limit = n0 + k;
      while (wr_cnt < w0 + k || tx_n < n0 + k) @(negedge clk_i);
      wr(4'h1, 32'h1);
      tx_limit = n0 + 60;
      wait_stopped();
      wr(4'h4, 32'h0);
      ok = 1;
      for (int i = 0; i < int'(k); i++) begin
        if (mem[8'(32'h60 + rep * 8 + i)] != rx_word(int'(s0) + i)) ok = 0;
        if (tx_got[6'(n0 + i)] != mem[8'(32'hA0 + rep * 8 + i)]) ok = 0;
      end
      check(ok, "R4", "concurrent rx/tx data and order (R5)", k, k);
      tx_limit = tx_n;
      rx_limit = rx_sent;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule